// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is a streaming stage in the pixel path of a dual-mode frame buffer. Each beat carries three things for one pixel: an 8-bit palette index from the indexed plane, a 32-bit word from the true-colour plane and a 32-bit word from the control plane. The top byte of the control word decides, pixel by pixel, whether the pixel shows the direct 24-bit colour or the palette entry named by its index. The palette itself sits outside the block and is reached through a read port with a fixed latency.

The chosen colour is packed into a 32-bit output word in RGB or BGR channel order, as a configuration input selects. Pixels leave in the order they arrived, through a valid/ready handshake on both sides. A small output queue absorbs downstream stalls, so the palette port never has to stall.

Top module: `pix_colour_select`

## Requirements
- R1: After a synchronous reset, out_valid and pal_rd_en are low and in_ready is high.
- R2: A pixel whose control word has bits [31:24] exactly equal to 8'h03 is a direct pixel and takes its colour from the true-colour word; bits [23:0] of the control word never change the result, and the palette read data is ignored for a direct pixel.
- R3: Any other control tag makes the pixel indexed: one cycle after it is accepted, pal_rd_en is high with pal_rd_addr equal to its index, and the output colour is the palette data returned PAL_LAT cycles after that read. A direct pixel causes no palette read.
- R4: In the true-colour word, bits [7:0] are red, [15:8] green and [23:16] blue; bits [31:24] are padding and ignored. Palette data is red in [23:16], green in [15:8], blue in [7:0].
- R5: With cfg_bgr low the output is red in [23:16], green in [15:8], blue in [7:0]; with cfg_bgr high blue is in [23:16], green in [15:8], red in [7:0]. cfg_bgr is sampled with each accepted pixel.
- R6: Bits [31:24] of out_pixel are zero whenever out_valid is high.
- R7: Pixels are emitted in acceptance order; a pixel accepted at a clock edge is presented no earlier than PAL_LAT+1 edges later, and exactly then when nothing is queued ahead of it.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_pixel holds; in_ready goes low once FIFO_DEPTH pixels are held in the block, and no pixel is lost or duplicated.
- R9: With out_ready held high and FIFO_DEPTH at least PAL_LAT+3, in_ready stays high and one pixel is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bgr | input | 1 | Output channel order: 0 RGB, 1 BGR |
| in_valid | input | 1 | Input pixel beat is valid |
| in_ready | output | 1 | Block can accept a beat |
| in_index | input | IDX_W | Palette index from the indexed plane |
| in_true | input | 32 | True-colour plane word |
| in_ctrl | input | 32 | Control plane word; [31:24] is the mode tag |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | IDX_W | Palette read address |
| pal_rd_data | input | 24 | Palette entry, PAL_LAT cycles after the read |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pixel | output | 32 | Packed output pixel, top byte zero |

## Verification
The hardest state to reach is a full block under backpressure while palette reads are still in flight: in_ready must fall at exactly the right occupancy and the pixels that land during the stall must still come out in order. The stimulus holds out_ready low for a stretch while in_valid stays high with a mix of direct and indexed tags, then releases it, and later alternates random valid and ready patterns. A reference model with a timestamped queue predicts in_ready, out_valid, out_pixel and every palette read on each clock. The bench palette returns a fixed junk value whenever no read was issued, so a direct pixel that wrongly used palette data shows up at once.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam logic [7:0] DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef struct packed {
    logic direct;
    logic bgr;
    rgb_t rgb;
  } meta_t;

  function automatic logic [31:0] pack_px(input logic bgr, input rgb_t c);
    if (bgr) return {8'h00, c.b, c.g, c.r};
    return {8'h00, c.r, c.g, c.b};
  endfunction

endpackage

// File: rtl/pcs_tag_decode.sv
module pcs_tag_decode
  import pcs_pkg::*;
(
  input  logic [31:0] ctrl_word,
  input  logic [31:0] true_word,
  output logic        direct,
  output rgb_t        colour
);

  logic unused_bits;

  assign direct   = (ctrl_word[31:24] == DIRECT_TAG);
  assign colour.r = true_word[7:0];
  assign colour.g = true_word[15:8];
  assign colour.b = true_word[23:16];
  assign unused_bits = ^{ctrl_word[23:0], true_word[31:24]};

endmodule

// File: rtl/pcs_delay.sv
module pcs_delay #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         v [LAT];
  logic [W-1:0] d [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) v[0] <= 1'b0;
        else     v[0] <= in_valid;
        d[0] <= in_data;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) v[g] <= 1'b0;
        else     v[g] <= v[g-1];
        d[g] <= d[g-1];
      end
    end
  end

  assign out_valid = v[LAT-1];
  assign out_data  = d[LAT-1];

endmodule

// File: rtl/pcs_fifo.sv
module pcs_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         not_empty,
  output logic [W-1:0] head
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_empty = (count != '0);
  assign head      = mem[rd_ptr];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < FULL) || pop);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

endmodule

// File: rtl/pix_colour_select.sv
module pix_colour_select
  import pcs_pkg::*;
#(
  parameter int PAL_LAT    = 2,
  parameter int FIFO_DEPTH = PAL_LAT + 3,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_bgr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [31:0]      in_true,
  input  logic [31:0]      in_ctrl,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_rd_addr,
  input  logic [23:0]      pal_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pixel
);

  localparam int MW = $bits(meta_t);
  localparam int OW = $clog2(FIFO_DEPTH + 1);
  localparam logic [OW-1:0] CAP = OW'(FIFO_DEPTH);

  logic in_fire, out_fire;
  assign in_fire  = in_valid & in_ready;
  assign out_fire = out_valid & out_ready;

  // Mode decode and direct-colour unpack
  logic dec_direct;
  rgb_t dec_rgb;

  pcs_tag_decode u_dec (
    .ctrl_word (in_ctrl),
    .true_word (in_true),
    .direct    (dec_direct),
    .colour    (dec_rgb)
  );

  // Issue stage: registered palette address
  logic             s0_valid;
  meta_t            s0_meta;
  logic [IDX_W-1:0] s0_idx;

  always_ff @(posedge clk) begin
    if (rst) s0_valid <= 1'b0;
    else     s0_valid <= in_fire;
    if (in_fire) begin
      s0_meta <= '{direct: dec_direct, bgr: cfg_bgr, rgb: dec_rgb};
      s0_idx  <= in_index;
    end
  end

  assign pal_rd_en   = s0_valid & ~s0_meta.direct;
  assign pal_rd_addr = s0_idx;

  // Latency match for the direct path
  logic          dl_valid;
  logic [MW-1:0] dl_bits;
  meta_t         dl_meta;

  pcs_delay #(.W(MW), .LAT(PAL_LAT)) u_delay (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s0_valid),
    .in_data   (s0_meta),
    .out_valid (dl_valid),
    .out_data  (dl_bits)
  );

  assign dl_meta = meta_t'(dl_bits);

  // Colour merge and channel packing
  rgb_t        sel_rgb;
  logic [31:0] merged_px;

  always_comb begin
    sel_rgb   = dl_meta.direct ? dl_meta.rgb : rgb_t'(pal_rd_data);
    merged_px = pack_px(dl_meta.bgr, sel_rgb);
  end

  // Output queue
  pcs_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (dl_valid),
    .push_data (merged_px),
    .pop       (out_fire),
    .not_empty (out_valid),
    .head      (out_pixel)
  );

  // Occupancy credit: pixels anywhere between acceptance and output
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else begin
      case ({in_fire, out_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign in_ready = (occ < CAP);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));

  assert_top_byte_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pixel[31:24] == 8'h00);

  assert_no_pal_direct_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_ctrl[31:24] == DIRECT_TAG) |=> !pal_rd_en);

  assert_pal_read_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_ctrl[31:24] != DIRECT_TAG)
      |=> pal_rd_en && (pal_rd_addr == $past(in_index)));

endmodule

// File: tb/tb_pix_colour_select.sv
`timescale 1ns/1ps
module tb_pix_colour_select;

  localparam int LAT   = 2;
  localparam int DEPTH = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bgr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_true = '0;
  logic [31:0] in_ctrl = '0;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_addr;
  logic [23:0] pal_rd_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixel;

  always #4 clk = ~clk;

  pix_colour_select #(.PAL_LAT(LAT), .FIFO_DEPTH(DEPTH), .IDX_W(8)) dut (
    .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .in_true(in_true), .in_ctrl(in_ctrl),
    .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  // Palette model: fixed contents, LAT-cycle read
  function automatic logic [23:0] pal_entry(input logic [7:0] i);
    logic [7:0] t;
    t = i * 8'd3;
    return {i ^ 8'h5A, t, ~i};
  endfunction

  logic        pv [LAT];
  logic [23:0] pd [LAT];

  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin
      pv[i] <= rst ? 1'b0 : pv[i-1];
      pd[i] <= pd[i-1];
    end
    pv[0] <= rst ? 1'b0 : pal_rd_en;
    pd[0] <= pal_entry(pal_rd_addr);
  end

  assign pal_rd_data = pv[LAT-1] ? pd[LAT-1] : 24'hA5A5A5;

  function automatic logic [31:0] expect_px(input logic [31:0] ctl,
      input logic [31:0] tc, input logic [7:0] idx, input logic bgr);
    logic [7:0] r, g, b;
    logic [23:0] p;
    if (ctl[31:24] == 8'h03) begin
      r = tc[7:0]; g = tc[15:8]; b = tc[23:16];
    end else begin
      p = pal_entry(idx);
      r = p[23:16]; g = p[15:8]; b = p[7:0];
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          q_time [$];
  logic [31:0] q_px   [$];
  int          iter = 0;
  bit          prev_ind = 0;
  logic [7:0]  prev_idx = '0;
  string       phase = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_ctrl(input int sel);
    logic [31:0] lo;
    lo = $urandom;
    case (sel % 8)
      0, 1, 2: return {8'h03, lo[23:0]};
      3:       return {8'h02, lo[23:0]};
      4:       return {8'h83, lo[23:0]};
      5:       return {8'h07, lo[23:0]};
      6:       return {8'hFF, lo[23:0]};
      default: return {8'h00, lo[23:0]};
    endcase
  endfunction

  // One cycle: check state, drive, update model
  task automatic step(input bit vin, input bit ordy, input bit bgr, input string req);
    bit          exp_rdy, exp_val, in_f, out_f;
    logic [31:0] ctl, tc, epx;
    logic [7:0]  idx;
    exp_rdy = (q_px.size() < DEPTH);
    exp_val = (q_px.size() != 0) && (q_time[0] <= iter);
    check(in_ready == exp_rdy, req, "in_ready", {31'd0, in_ready}, {31'd0, exp_rdy});
    check(out_valid == exp_val, "R7", "out_valid timing", {31'd0, out_valid}, {31'd0, exp_val});
    if (exp_val && out_valid) begin
      check(out_pixel == q_px[0], req, "out_pixel", out_pixel, q_px[0]);
      check(out_pixel[31:24] == 8'h00, "R6", "top byte", out_pixel, q_px[0]);
    end
    check(pal_rd_en == prev_ind, "R3", "pal_rd_en", {31'd0, pal_rd_en}, {31'd0, prev_ind});
    if (prev_ind)
      check(pal_rd_addr == prev_idx, "R3", "pal_rd_addr", {24'd0, pal_rd_addr}, {24'd0, prev_idx});

    ctl = pick_ctrl(int'($urandom % 8));
    tc  = $urandom;
    idx = 8'($urandom);
    in_valid  = vin;
    out_ready = ordy;
    cfg_bgr   = bgr;
    in_ctrl   = ctl;
    in_true   = tc;
    in_index  = idx;

    in_f  = vin && exp_rdy;
    out_f = exp_val && ordy;
    if (out_f) begin
      void'(q_px.pop_front());
      void'(q_time.pop_front());
    end
    if (in_f) begin
      epx = expect_px(ctl, tc, idx, bgr);
      q_px.push_back(epx);
      q_time.push_back(iter + LAT + 2);
    end
    prev_ind = in_f && (ctl[31:24] != 8'h03);
    prev_idx = idx;
    iter++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(pal_rd_en == 1'b0, "R1", "pal_rd_en after reset", {31'd0, pal_rd_en}, 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R9 / R2 / R4: full-rate stream, RGB order
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, "R9");
    // R5: BGR order, still full rate; R2 tags mixed
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b1, "R5");
    // R8: stall output until the block fills, then release
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1, "R8");
    // R7 / R2 / R4: random valid and ready patterns
    for (int i = 0; i < 400; i++)
      step(bit'($urandom % 3 != 0), bit'($urandom % 2), bit'($urandom % 2), "R2 R4");
    // drain
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, "R7");
    check(q_px.size() == 0, "R8", "pixels left after drain", q_px.size(), 32'd0);
    check(out_valid == 1'b0, "R8", "out_valid after drain", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule